// File: doc/BRIEF.md
# Working/Architectural Register File Pair with Bulk Recovery

This block holds the integer registers of a speculative pipeline in two copies. Operands are read from the working copy early in the pipe, and results land in the working copy as soon as they finish executing, before they are known to be safe. A separate retire path writes the architectural copy, but only when an instruction reaches the end of the pipe. When the pipeline is flushed, for example on an exception, the architectural copy is moved in bulk into the working copy. Every speculative value is then gone, and execution restarts from the committed state.

There are three speculative write ports: two for ALU/shift results and one for load data. There are also three retire ports and four read ports. A recovery copies `CHUNK` registers per cycle. While it runs, `restore_busy` is high and `rd_stall` tells the issuing stage that read data is not valid. The consumer must hold its read request and retry once `rd_stall` falls; no read is accepted during that time. Register 0 is hard-wired to zero in both copies.

Top module: `ffrf_top`

## Requirements
- R1: After reset, every register in both copies reads as zero, and `restore_busy`, `restore_done` and `rd_stall` are low.
- R2: Register 0 reads as zero on every read port, and writes to it from any port are dropped.
- R3: A speculative write on any port with `sp_we` high is visible on the read ports from the cycle after the write edge. Reads are combinational from the working copy.
- R4: When several speculative ports write the same register in one cycle, the value from the highest-numbered port is kept.
- R5: Retire writes update only the architectural copy, and the working copy reads its previous value afterwards.
- R6: After a recovery completes, every register of the working copy equals the architectural copy.
- R7: A `flush_req` sampled while idle raises `restore_busy` from the next cycle. `restore_busy` stays high for NREG/CHUNK cycles (4 by default). `restore_done` is high for exactly one cycle, the first cycle in which `restore_busy` is low again. `rd_stall` equals `restore_busy`.
- R8: A retire write presented in the same cycle as an accepted `flush_req` is part of the state that the recovery copies.
- R9: While `restore_busy` is high, speculative writes are dropped and a further `flush_req` has no effect, so no second recovery follows.
- R10: When several retire ports write the same register in one cycle, the value from the highest-numbered port is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 4x5 | Read register numbers, one per read port |
| rd_data | output | 4x64 | Working-copy read data, one per read port |
| rd_stall | output | 1 | Read data not valid; hold the request |
| sp_we | input | 3 | Speculative write enables (ports 0,1 ALU, port 2 load) |
| sp_addr | input | 3x5 | Speculative write register numbers |
| sp_data | input | 3x64 | Speculative write data |
| rt_we | input | 3 | Retire write enables |
| rt_addr | input | 3x5 | Retire register numbers |
| rt_data | input | 3x64 | Retire data |
| flush_req | input | 1 | Request to restore the working copy from the architectural copy |
| restore_busy | output | 1 | Recovery copy in progress |
| restore_done | output | 1 | One-cycle pulse when the recovery finishes |

## Verification
The hardest case is a recovery that has to pick up a retire write arriving in the flush cycle while speculative writes and a second flush request are pushed in mid-copy. The stimulus first makes the two copies diverge on purpose: speculative and retire writes with different values to the same registers. It then fires the flush together with a retire write, drives a speculative write and a second flush during the busy window, and checks every register against a model of the architectural copy. Port-priority collisions on both write paths are forced by aiming all three ports at one register in a single cycle.

// File: rtl/ffrf_pkg.sv
package ffrf_pkg;
  localparam int unsigned DEF_NREG  = 32;
  localparam int unsigned DEF_W     = 64;
  localparam int unsigned DEF_CHUNK = 8;

  typedef enum logic { RC_IDLE = 1'b0, RC_COPY = 1'b1 } rc_state_e;
endpackage

// File: rtl/ffrf_arch_bank.sv
module ffrf_arch_bank #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned W     = 64,
  parameter int unsigned NWP   = 3,
  parameter int unsigned CHUNK = 8,
  localparam int unsigned AW     = $clog2(NREG),
  localparam int unsigned NCHUNK = NREG / CHUNK,
  localparam int unsigned CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWP-1:0]           wr_en,
  input  logic [NWP-1:0][AW-1:0]   wr_addr,
  input  logic [NWP-1:0][W-1:0]    wr_data,
  input  logic [CW-1:0]            grp_sel,
  output logic [CHUNK-1:0][W-1:0]  grp_data
);
  logic [W-1:0] cells [NREG];
  logic [W-1:0] cells_nxt [NREG];

  assign cells[0]     = '0;
  assign cells_nxt[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_cell
    always_comb begin
      cells_nxt[r] = cells[r];
      for (int p = 0; p < NWP; p++) begin
        if (wr_en[p] && (wr_addr[p] == AW'(r))) cells_nxt[r] = wr_data[p];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cells[r] <= '0;
      else        cells[r] <= cells_nxt[r];
    end
  end

  for (genvar j = 0; j < CHUNK; j++) begin : g_grp
    assign grp_data[j] = cells[int'(grp_sel) * CHUNK + j];
  end

  // R10: the top port's value is what the architectural copy holds next cycle
  assert_retire_top_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[NWP-1] && wr_addr[NWP-1] != '0)
      |=> cells[$past(wr_addr[NWP-1])] == $past(wr_data[NWP-1]));
endmodule

// File: rtl/ffrf_work_bank.sv
module ffrf_work_bank #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned W     = 64,
  parameter int unsigned NWP   = 3,
  parameter int unsigned NRD   = 4,
  parameter int unsigned CHUNK = 8,
  localparam int unsigned AW     = $clog2(NREG),
  localparam int unsigned NCHUNK = NREG / CHUNK,
  localparam int unsigned CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWP-1:0]           wr_en,
  input  logic [NWP-1:0][AW-1:0]   wr_addr,
  input  logic [NWP-1:0][W-1:0]    wr_data,
  input  logic                     load_en,
  input  logic [CW-1:0]            load_sel,
  input  logic [CHUNK-1:0][W-1:0]  load_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][W-1:0]    rd_data
);
  logic [W-1:0] cells [NREG];
  logic [W-1:0] cells_nxt [NREG];

  assign cells[0]     = '0;
  assign cells_nxt[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_cell
    localparam int unsigned GRP  = r / CHUNK;
    localparam int unsigned SLOT = r % CHUNK;
    always_comb begin
      cells_nxt[r] = cells[r];
      for (int p = 0; p < NWP; p++) begin
        if (wr_en[p] && (wr_addr[p] == AW'(r))) cells_nxt[r] = wr_data[p];
      end
      if (load_en && (load_sel == CW'(GRP))) cells_nxt[r] = load_data[SLOT];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cells[r] <= '0;
      else        cells[r] <= cells_nxt[r];
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data[k] = cells[rd_addr[k]];
    // R2: register zero never returns a non-zero value
    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[k] == '0) |-> (rd_data[k] == '0));
  end

  // R3/R4: the top speculative port's value is readable after the edge
  assert_spec_top_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[NWP-1] && wr_addr[NWP-1] != '0 && !load_en)
      |=> cells[$past(wr_addr[NWP-1])] == $past(wr_data[NWP-1]));
endmodule

// File: rtl/ffrf_restore_ctl.sv
module ffrf_restore_ctl
  import ffrf_pkg::*;
#(
  parameter int unsigned NREG  = 32,
  parameter int unsigned CHUNK = 8,
  localparam int unsigned NCHUNK = NREG / CHUNK,
  localparam int unsigned CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_req,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] grp
);
  localparam logic [CW-1:0] LAST_GRP = CW'(NCHUNK - 1);

  rc_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RC_IDLE;
      grp   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RC_IDLE: if (flush_req) begin
          state <= RC_COPY;
          grp   <= '0;
        end
        RC_COPY: begin
          if (grp == LAST_GRP) begin
            state <= RC_IDLE;
            done  <= 1'b1;
          end else begin
            grp <= grp + 1'b1;
          end
        end
        default: state <= RC_IDLE;
      endcase
    end
  end

  assign busy = (state == RC_COPY);

  // R7: the last group ends the copy
  assert_copy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grp == LAST_GRP) |=> !busy);
  // R7: done follows a busy cycle and never overlaps it
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9: a request while copying does not restart the group count
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grp != LAST_GRP) |=> (busy && grp == $past(grp) + 1'b1));
endmodule

// File: rtl/ffrf_top.sv
module ffrf_top
  import ffrf_pkg::*;
#(
  parameter int unsigned NREG  = DEF_NREG,
  parameter int unsigned W     = DEF_W,
  parameter int unsigned NRD   = 4,
  parameter int unsigned NSP   = 3,
  parameter int unsigned NRT   = 3,
  parameter int unsigned CHUNK = DEF_CHUNK,
  localparam int unsigned AW     = $clog2(NREG),
  localparam int unsigned NCHUNK = NREG / CHUNK,
  localparam int unsigned CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][W-1:0]  rd_data,
  output logic                   rd_stall,
  input  logic [NSP-1:0]         sp_we,
  input  logic [NSP-1:0][AW-1:0] sp_addr,
  input  logic [NSP-1:0][W-1:0]  sp_data,
  input  logic [NRT-1:0]         rt_we,
  input  logic [NRT-1:0][AW-1:0] rt_addr,
  input  logic [NRT-1:0][W-1:0]  rt_data,
  input  logic                   flush_req,
  output logic                   restore_busy,
  output logic                   restore_done
);
  logic                    busy;
  logic [CW-1:0]           grp;
  logic [CHUNK-1:0][W-1:0] grp_data;
  logic [NSP-1:0]          sp_we_gated;

  assign sp_we_gated  = busy ? '0 : sp_we;
  assign rd_stall     = busy;
  assign restore_busy = busy;

  ffrf_restore_ctl #(.NREG(NREG), .CHUNK(CHUNK)) u_ctl (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
    .busy(busy), .done(restore_done), .grp(grp)
  );

  ffrf_arch_bank #(.NREG(NREG), .W(W), .NWP(NRT), .CHUNK(CHUNK)) u_arch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rt_we), .wr_addr(rt_addr), .wr_data(rt_data),
    .grp_sel(grp), .grp_data(grp_data)
  );

  ffrf_work_bank #(.NREG(NREG), .W(W), .NWP(NSP), .NRD(NRD), .CHUNK(CHUNK)) u_work (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sp_we_gated), .wr_addr(sp_addr), .wr_data(sp_data),
    .load_en(busy), .load_sel(grp), .load_data(grp_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R7: an idle flush request starts a copy on the next cycle
  assert_flush_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy) |=> busy);
endmodule

// File: tb/ffrf_top_bench.sv
module ffrf_top_bench;
  localparam int NREG = 32;
  localparam int W    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0][4:0]  rd_addr = '0;
  logic [3:0][63:0] rd_data;
  logic             rd_stall;
  logic [2:0]       sp_we = '0;
  logic [2:0][4:0]  sp_addr = '0;
  logic [2:0][63:0] sp_data = '0;
  logic [2:0]       rt_we = '0;
  logic [2:0][4:0]  rt_addr = '0;
  logic [2:0][63:0] rt_data = '0;
  logic             flush_req = 1'b0;
  logic             restore_busy, restore_done;

  logic [63:0] wm [NREG];
  logic [63:0] am [NREG];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ffrf_top u_ffrf_top (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_stall(rd_stall),
    .sp_we(sp_we), .sp_addr(sp_addr), .sp_data(sp_data),
    .rt_we(rt_we), .rt_addr(rt_addr), .rt_data(rt_data),
    .flush_req(flush_req), .restore_busy(restore_busy), .restore_done(restore_done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input int r, input logic [63:0] exp);
    rd_addr[r % 4] = 5'(r);
    #1;
    check(tag, rd_data[r % 4], exp);
  endtask

  task automatic spec_wr(input int p, input int r, input logic [63:0] d);
    sp_we[p] = 1'b1; sp_addr[p] = 5'(r); sp_data[p] = d;
  endtask

  task automatic ret_wr(input int p, input int r, input logic [63:0] d);
    rt_we[p] = 1'b1; rt_addr[p] = 5'(r); rt_data[p] = d;
  endtask

  task automatic clear_wr();
    sp_we = '0; rt_we = '0;
  endtask

  // apply the driven writes to the models, port order giving priority
  task automatic commit_models(input bit spec_ok);
    for (int p = 0; p < 3; p++) begin
      if (spec_ok && sp_we[p] && sp_addr[p] != 0) wm[sp_addr[p]] = sp_data[p];
      if (rt_we[p] && rt_addr[p] != 0) am[rt_addr[p]] = rt_data[p];
    end
  endtask

  task automatic t_reset();
    check("R1 busy", 64'(restore_busy), 0);
    check("R1 done", 64'(restore_done), 0);
    check("R1 stall", 64'(rd_stall), 0);
    for (int r = 0; r < NREG; r++) rd_chk("R1 reg", r, 0);
  endtask

  task automatic t_spec();
    spec_wr(0, 3, 64'h1111_0000_0000_0003);
    spec_wr(1, 17, 64'h2222_0000_0000_0011);
    spec_wr(2, 31, 64'h3333_0000_0000_001F);
    commit_models(1); cyc(); clear_wr();
    rd_chk("R3 p0", 3, wm[3]);
    rd_chk("R3 p1", 17, wm[17]);
    rd_chk("R3 p2", 31, wm[31]);
    spec_wr(1, 0, 64'hDEAD_BEEF_0000_0001);
    ret_wr(0, 0, 64'hDEAD_BEEF_0000_0002);
    cyc(); clear_wr();
    for (int k = 0; k < 4; k++) begin
      rd_addr[k] = 5'd0; #1;
      check("R2 zero", rd_data[k], 0);
    end
  endtask

  task automatic t_spec_conflict();
    spec_wr(0, 9, 64'hAAAA_0000_0000_0000);
    spec_wr(1, 9, 64'hBBBB_0000_0000_0000);
    spec_wr(2, 9, 64'hCCCC_0000_0000_0000);
    commit_models(1); cyc(); clear_wr();
    rd_chk("R4 top port", 9, 64'hCCCC_0000_0000_0000);
    spec_wr(0, 10, 64'h0A0A_0000_0000_0000);
    spec_wr(1, 10, 64'h0B0B_0000_0000_0000);
    commit_models(1); cyc(); clear_wr();
    rd_chk("R4 port1 over port0", 10, 64'h0B0B_0000_0000_0000);
  endtask

  task automatic t_retire_isolated();
    ret_wr(0, 3, 64'h5555_0000_0000_0003);
    ret_wr(1, 20, 64'h5555_0000_0000_0014);
    commit_models(0); cyc(); clear_wr();
    rd_chk("R5 working kept", 3, wm[3]);
    rd_chk("R5 working kept", 20, wm[20]);
    ret_wr(0, 12, 64'h0C00_0000_0000_0001);
    ret_wr(1, 12, 64'h0C00_0000_0000_0002);
    ret_wr(2, 12, 64'h0C00_0000_0000_0003);
    commit_models(0); cyc(); clear_wr();
    for (int r = 1; r < NREG; r += 2) begin
      spec_wr(0, r, 64'hF00D_0000_0000_0000 | 64'(r));
      commit_models(1); cyc(); clear_wr();
    end
  endtask

  task automatic t_flush();
    ret_wr(2, 25, 64'h7777_0000_0000_0019);
    flush_req = 1'b1;
    commit_models(0); cyc(); clear_wr(); flush_req = 1'b0;
    for (int c = 0; c < 4; c++) begin
      check("R7 busy", 64'(restore_busy), 1);
      check("R7 stall", 64'(rd_stall), 1);
      check("R7 no done", 64'(restore_done), 0);
      if (c == 1) spec_wr(0, 9, 64'hBAD0_0000_0000_0009);
      if (c == 2) flush_req = 1'b1;
      cyc(); clear_wr(); flush_req = 1'b0;
    end
    check("R7 busy low", 64'(restore_busy), 0);
    check("R7 done pulse", 64'(restore_done), 1);
    cyc();
    check("R7 done single", 64'(restore_done), 0);
    check("R9 no second copy", 64'(restore_busy), 0);
    for (int r = 0; r < NREG; r++) wm[r] = am[r];
    for (int r = 0; r < NREG; r++) rd_chk("R6 restored", r, am[r]);
    rd_chk("R8 flush-cycle retire", 25, 64'h7777_0000_0000_0019);
    rd_chk("R9 busy write dropped", 9, 0);
    rd_chk("R10 retire top port", 12, 64'h0C00_0000_0000_0003);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin wm[r] = '0; am[r] = '0; end
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_spec();
    t_spec_conflict();
    t_retire_isolated();
    t_flush();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule